// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32768 Hz tick strobe into a periodic event whose rate is chosen by a 4-bit rate code. A free-running counter advances once per tick. An event fires on each tick that brings that counter to an exact multiple of the selected period. Because of this, events stay locked to the time base whatever the moment the rate or the enables were programmed.

Each event can do two things, each behind its own enable. With the interrupt enable set, it sets two sticky status flags and raises an interrupt line. With the square-wave enable set, it emits a single-cycle pulse. The flags are cleared by a clear strobe, which the host side issues when it reads the status.

Top module: `rate_event_gen`

## Requirements
- R1: After reset, status_o is 0x00 and irq_o and sqw_o are low.
- R2: With rate code 0 no event is produced, whatever the enables are.
- R3: Rate codes 1 and 2 act as codes 8 and 9, giving periods of 128 and 256 ticks.
- R4: For rate codes 3 to 15 the period is 2^(code-1) ticks.
- R5: With both enables low no event is produced: sqw_o stays low and the flags are not set.
- R6: Tick n is counted from 1 after reset. An event fires on tick n exactly when the generator runs and n is a multiple of the period. Its effect shows at the outputs after the clock edge that samples that tick.
- R7: An event while pie_en_i is high sets status_o bit 7 (request) and bit 6 (periodic), and irq_o follows bit 7. All other status bits read 0.
- R8: An event while sqw_en_i is high drives sqw_o high for exactly one cycle. The square-wave path alone never sets the flags.
- R9: A change of rate code or enables takes effect at the next multiple of the new period, with no event at the moment of the change.
- R10: stat_clr_i clears bits 7 and 6 and irq_o on the next edge. An event in the same cycle wins over the clear.
- R11: The base counter advances only in cycles with tick_i high, so no event occurs in a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 32768 Hz |
| rate_code_i | input | 4 | Rate select, 0 disables |
| pie_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave pulse enable |
| stat_clr_i | input | 1 | Clear strobe for the status flags |
| status_o | output | 8 | Status flags: bit 7 request, bit 6 periodic |
| irq_o | output | 1 | Interrupt request line |
| sqw_o | output | 1 | One-cycle event pulse |

## Verification
Every rate code from 1 to 15 is swept with the pulse output enabled. The spacing of two consecutive events tells the folded codes 1 and 2 apart from a plain power-of-two mapping, and the tick index of the first event shows alignment to the base counter. Sparse tick patterns separate counting on clock edges from counting on ticks. A code switch in mid-period shows whether the new period restarts from the change or snaps to the shared base counter. Clear strobes placed on and off event cycles expose the precedence between setting and clearing the flags.

// File: rtl/rate_event_pkg.sv
package rate_event_pkg;
  localparam int CODE_W   = 4;
  localparam int STAT_W   = 8;
  localparam int IRQF_BIT = 7;
  localparam int PF_BIT   = 6;
  localparam int FOLD_MAX = 2;
  localparam int FOLD_ADD = 7;
endpackage

// File: rtl/rate_decode.sv
module rate_decode
  import rate_event_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              zero_o,
  output logic [CNT_W-1:0]  mask_o
);
  logic [CODE_W-1:0] eff;
  logic [CODE_W-1:0] shift;

  always_comb begin
    eff = code_i;
    if (code_i != '0 && int'(code_i) <= FOLD_MAX) eff = code_i + CODE_W'(FOLD_ADD);
    shift = (code_i == '0) ? '0 : eff - CODE_W'(1);
  end

  assign zero_o = (code_i == '0);

  // low (eff-1) bits of the counter form the alignment window
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = (int'(shift) > i);
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt_o;
  end

  p_cnt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/event_flags.sv
module event_flags
  import rate_event_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] status_o
);
  logic irqf_q, pf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irqf_q <= 1'b0;
      pf_q   <= 1'b0;
    end else if (set_i) begin
      irqf_q <= 1'b1;
      pf_q   <= 1'b1;
    end else if (clr_i) begin
      irqf_q <= 1'b0;
      pf_q   <= 1'b0;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[IRQF_BIT] = irqf_q;
    status_o[PF_BIT]   = pf_q;
  end

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> status_o[IRQF_BIT] && status_o[PF_BIT]);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !status_o[IRQF_BIT] && !status_o[PF_BIT]);
endmodule

// File: rtl/rate_event_gen.sv
module rate_event_gen
  import rate_event_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              pie_en_i,
  input  logic              sqw_en_i,
  input  logic              stat_clr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              sqw_o
);
  logic             code_zero;
  logic [CNT_W-1:0] win_mask;
  logic [CNT_W-1:0] cnt_nxt;
  logic             run;
  logic             hit;
  logic             sqw_q;

  rate_decode #(.CNT_W(CNT_W)) u_dec (
    .code_i (rate_code_i),
    .zero_o (code_zero),
    .mask_o (win_mask)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .cnt_nxt_o (cnt_nxt)
  );

  // event on the tick that lands the base counter on a period multiple
  assign run = !code_zero && (pie_en_i || sqw_en_i);
  assign hit = tick_i && run && ((cnt_nxt & win_mask) == '0);

  event_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (hit && pie_en_i),
    .clr_i    (stat_clr_i),
    .status_o (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sqw_q <= 1'b0;
    else         sqw_q <= hit && sqw_en_i;
  end

  assign sqw_o = sqw_q;
  assign irq_o = status_o[IRQF_BIT];

  p_code0_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_code_i == '0) |=> !sqw_o && !$rose(irq_o));
  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pie_en_i && !sqw_en_i) |=> !sqw_o && !$rose(irq_o));
  p_flag_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[IRQF_BIT] == status_o[PF_BIT]);
  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sqw_o |=> !sqw_o);
  p_tick_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !sqw_o && !$rose(irq_o));
endmodule

// File: tb/rate_event_gen_bench.sv
module rate_event_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [3:0] rate_code_i = 4'd0;
  logic       pie_en_i = 1'b0;
  logic       sqw_en_i = 1'b0;
  logic       stat_clr_i = 1'b0;
  logic [7:0] status_o;
  logic       irq_o;
  logic       sqw_o;

  int errors = 0;
  int checks = 0;
  int tick_n = 0;
  int last_ev = -1;
  int ev_cnt = 0;
  bit exp_flag = 1'b0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  rate_event_gen u_rate_event_gen (
    .clk_i, .rst_ni, .tick_i, .rate_code_i, .pie_en_i, .sqw_en_i,
    .stat_clr_i, .status_o, .irq_o, .sqw_o
  );

  function automatic int period_of(input int c);
    int eff;
    eff = (c == 1) ? 8 : (c == 2) ? 9 : c;
    return 1 << (eff - 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle; model derived from R6/R7/R8/R10/R11, compared after the edge
  task automatic step(input bit t);
    bit ev, exp_sqw;
    @(negedge clk_i);
    tick_i = t;
    if (t) tick_n++;
    ev = t && rate_code_i != 0 && (pie_en_i || sqw_en_i)
         && (tick_n % period_of(int'(rate_code_i)) == 0);
    exp_sqw = ev && sqw_en_i;
    if (ev && pie_en_i) exp_flag = 1'b1;
    else if (stat_clr_i) exp_flag = 1'b0;
    @(posedge clk_i);
    #1;
    chk("R6/R8 sqw_o", int'(sqw_o), int'(exp_sqw));
    chk("R7/R10 status_o", int'(status_o), exp_flag ? 'hC0 : 0);
    chk("R7 irq_o", int'(irq_o), int'(exp_flag));
    if (sqw_o) begin
      last_ev = tick_n;
      ev_cnt++;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1
    chk("R1 status_o", int'(status_o), 0);
    chk("R1 irq_o", int'(irq_o), 0);
    chk("R1 sqw_o", int'(sqw_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: code 0 with both enables
    pie_en_i = 1'b1; sqw_en_i = 1'b1; rate_code_i = 4'd0;
    ev_cnt = 0;
    for (int i = 0; i < 600; i++) step(1'b1);
    chk("R2 events with code 0", ev_cnt, 0);
    chk("R2 status_o", int'(status_o), 0);

    // R5: enables low
    pie_en_i = 1'b0; sqw_en_i = 1'b0; rate_code_i = 4'd3;
    for (int i = 0; i < 40; i++) step(1'b1);
    chk("R5 events gated", ev_cnt, 0);
    chk("R5 status_o", int'(status_o), 0);

    // R7: interrupt only, no pulse
    pie_en_i = 1'b1;
    for (int i = 0; i < 8; i++) step(1'b1);
    chk("R7 flags set", int'(status_o), 'hC0);
    chk("R8 no pulse without enable", ev_cnt, 0);

    // R10: clear off an event cycle
    stat_clr_i = 1'b1;
    step(1'b0);
    stat_clr_i = 1'b0;
    chk("R10 cleared", int'(irq_o), 0);
    // R10: clear on an event tick, set wins
    while (tick_n % 4 != 3) step(1'b1);
    stat_clr_i = 1'b1;
    step(1'b1);
    stat_clr_i = 1'b0;
    chk("R10 set wins", int'(status_o), 'hC0);
    stat_clr_i = 1'b1; step(1'b0); stat_clr_i = 1'b0;
    pie_en_i = 1'b0;

    // R11: sparse ticks, code 3 -> 4 ticks = 12 cycles with tick every 3rd
    sqw_en_i = 1'b1;
    begin
      int cyc, first_cyc, gap;
      cyc = 0; first_cyc = -1; gap = -1;
      for (int i = 0; i < 60; i++) begin
        step(i % 3 == 0);
        cyc++;
        if (sqw_o) begin
          if (first_cyc >= 0 && gap < 0) gap = cyc - first_cyc;
          if (first_cyc < 0) first_cyc = cyc;
        end
      end
      chk("R11 cycle gap with sparse ticks", gap, 12);
      chk("R8 no flags from pulse path", int'(status_o), 0);
    end

    // R9: switch code 3 -> 6 in mid-period
    while (tick_n % 32 != 5) step(1'b1);
    rate_code_i = 4'd6;
    ev_cnt = 0;
    begin
      int start;
      start = tick_n;
      while (ev_cnt == 0 && tick_n < start + 100) step(1'b1);
      chk("R9 first event after change", last_ev, start - 5 + 32);
    end

    // R3/R4/R6: spacing sweep over codes 1..15
    for (int c = 1; c < 16; c++) begin
      int p, first, lim;
      p = period_of(c);
      rate_code_i = 4'(c);
      ev_cnt = 0;
      first = -1;
      lim = tick_n + 3 * p + 4;
      while (ev_cnt < 2 && tick_n < lim) begin
        step(1'b1);
        if (sqw_o && first < 0) first = tick_n;
      end
      chk(c <= 2 ? "R3 folded spacing" : "R4 spacing", last_ev - first, p);
      chk("R6 aligned to base", first % p, 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule